// File: doc/BRIEF.md
# Four-Mode Byte-Pair Timer/Counter

This block is a small timer/counter built from one pair of 8-bit count registers, a low byte and a high byte. Two mode bits give four counting structures. Mode 0 is a 13-bit counter that uses five low-byte bits as a prescaler under the high byte. Mode 1 is a full 16-bit counter. Mode 2 is an 8-bit counter in the low byte that reloads from the high byte. Mode 3 splits the pair into two independent 8-bit counters.

The main counter steps once per machine cycle, which is a fixed number of system clocks (twelve by default). It can also step once per rising edge on an external count input. Each wrap from all ones to zero sets an overflow flag. The flags drive an interrupt request that can be masked.

Software presets the count so that the counter wraps after the number of steps it wants. For example, a 16-bit preset of 0xFC18 wraps after 1000 steps. All state sits behind a byte-wide register port with a combinational read.

Top module: `cyc_timer`

## Requirements
- R1: After reset, all four registers read 0x00, and `ovf_o`, `ovf_hi_o` and `irq_o` are low.
- R2: The register addresses are 0 for the low count byte, 1 for the high count byte, 2 for mode (bits 1:0) and 3 for control. Control bit 0 runs the main counter and bit 1 runs the split-mode high counter. Bit 2 selects external counting. Bit 3 is the main overflow flag, bit 4 is the high overflow flag and bit 5 is the interrupt enable. Bits 7:6 read 0. Every register reads back the value it holds.
- R3: In timer operation (control bit 2 = 0), a running counter steps once every CLK_DIV clocks. The first step lands on the CLK_DIV-th rising edge after the edge that wrote the run bit. The prescaler restarts whenever both run bits are 0.
- R4: Mode 0 counts in low[4:0] with carry into the high byte, and low[7:5] hold their value. A step from high = 0xFF and low[4:0] = 0x1F gives zero and sets the main flag.
- R5: Mode 1 counts {high, low} as 16 bits, and a step from 0xFFFF gives 0x0000 and sets the main flag. A preset of 0xFC18 reaches 0xFFFF after 999 steps and wraps on step 1000.
- R6: In mode 2, a step from low = 0xFF loads the high byte into the low byte and sets the main flag. The high byte does not change.
- R7: In mode 3, the low byte counts under control bit 0 with the selected source. The high byte counts machine cycles under control bit 1, and its wrap sets the high flag (`ovf_hi_o`) only.
- R8: With control bit 2 = 1, the main counter steps once for each 0→1 change on `cnt_in_i`, on the first clock edge that sees the input high. A held high level gives no further steps, and nothing is counted while control bit 0 is 0.
- R9: A write to a count byte takes the written value in place of any step in the same cycle. In modes 0 to 2, a write to either count byte cancels that cycle's step of the main counter. In mode 3, each write cancels the step of its own byte only.
- R10: A pulse on `irq_ack_i` clears both flags. A control write loads both flags from data bits 3 and 4. A wrap in the same cycle as either of these still sets its flag.
- R11: `irq_o` is high exactly when the interrupt enable is set and at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from address |
| cnt_in_i | input | 1 | External count input, synchronous to clk_i |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears both flags |
| ovf_o | output | 1 | Main overflow flag |
| ovf_hi_o | output | 1 | Split-mode high-byte overflow flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A register write shows on the read port one clock after its edge. An external rising edge is counted on the same edge that first sees it high. A timer step lands exactly CLK_DIV edges after the previous one, counting from the run write. The bench drives each input at a falling edge and then waits an exact number of falling edges before it reads. Every comparison therefore falls in the half-cycle after the edge that should have produced the result. For the long 16-bit case this means one read one cycle before the wrap and one read right after it.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PRE13_W = 5;

  typedef enum logic [1:0] {
    MODE_13B    = 2'd0,
    MODE_16B    = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } tmr_mode_e;

  localparam logic [1:0] ADDR_LO   = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_MODE = 2'd2;
  localparam logic [1:0] ADDR_CTRL = 2'd3;

  localparam int unsigned CTL_RUN    = 0;
  localparam int unsigned CTL_RUN_HI = 1;
  localparam int unsigned CTL_EXT    = 2;
  localparam int unsigned CTL_OVF    = 3;
  localparam int unsigned CTL_OVF_HI = 4;
  localparam int unsigned CTL_IE     = 5;
endpackage

// File: rtl/cyc_timer_tick.sv
module cyc_timer_tick #(
  parameter int unsigned DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      pre_q <= '0;
    else if (!en_i || pre_q == LAST)  pre_q <= '0;
    else                              pre_q <= pre_q + 1'b1;
  end

  assign tick_o = en_i && (pre_q == LAST);
endmodule

// File: rtl/cyc_timer_src.sv
module cyc_timer_src (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cnt_in_i,
  input  logic ext_sel_i,
  input  logic tick_i,
  output logic step_o
);
  logic cnt_d_q;

  // reset high so an input already high at reset is not a count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_d_q <= 1'b1;
    else         cnt_d_q <= cnt_in_i;
  end

  assign step_o = ext_sel_i ? (cnt_in_i & ~cnt_d_q) : tick_i;
endmodule

// File: rtl/cyc_timer_core.sv
module cyc_timer_core
  import cyc_timer_pkg::*;
(
  input  tmr_mode_e         mode_i,
  input  logic [BYTE_W-1:0] lo_i,
  input  logic [BYTE_W-1:0] hi_i,
  input  logic              step_lo_i,
  input  logic              step_hi_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              ovf_lo_o,
  output logic              ovf_hi_o
);
  always_comb begin
    lo_o     = lo_i;
    hi_o     = hi_i;
    ovf_lo_o = 1'b0;
    ovf_hi_o = 1'b0;
    case (mode_i)
      MODE_13B: if (step_lo_i) begin
        lo_o[PRE13_W-1:0] = lo_i[PRE13_W-1:0] + 1'b1;
        if (&lo_i[PRE13_W-1:0]) begin
          hi_o     = hi_i + 1'b1;
          ovf_lo_o = &hi_i;
        end
      end
      MODE_16B: if (step_lo_i) begin
        {hi_o, lo_o} = {hi_i, lo_i} + 1'b1;
        ovf_lo_o     = &{hi_i, lo_i};
      end
      MODE_RELOAD: if (step_lo_i) begin
        if (&lo_i) begin
          lo_o     = hi_i;
          ovf_lo_o = 1'b1;
        end else begin
          lo_o = lo_i + 1'b1;
        end
      end
      default: begin
        if (step_lo_i) begin
          lo_o     = lo_i + 1'b1;
          ovf_lo_o = &lo_i;
        end
        if (step_hi_i) begin
          hi_o     = hi_i + 1'b1;
          ovf_hi_o = &hi_i;
        end
      end
    endcase
  end
endmodule

// File: rtl/cyc_timer.sv
module cyc_timer
  import cyc_timer_pkg::*;
#(
  parameter int unsigned CLK_DIV = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  input  logic              cnt_in_i,
  input  logic              irq_ack_i,
  output logic              ovf_o,
  output logic              ovf_hi_o,
  output logic              irq_o
);
  logic [BYTE_W-1:0] cnt_lo_q, cnt_hi_q, lo_nxt, hi_nxt;
  tmr_mode_e mode_q;
  logic run_lo_q, run_hi_q, ext_q, ie_q, ovf_q, ovf_hi_q;
  logic wr_lo, wr_hi, wr_mode, wr_ctrl;
  logic tick, step_main, split, cancel_lo, inc_lo, inc_hi, evt_lo, evt_hi;

  assign wr_lo   = reg_we_i && reg_addr_i == ADDR_LO;
  assign wr_hi   = reg_we_i && reg_addr_i == ADDR_HI;
  assign wr_mode = reg_we_i && reg_addr_i == ADDR_MODE;
  assign wr_ctrl = reg_we_i && reg_addr_i == ADDR_CTRL;

  cyc_timer_tick #(.DIV(CLK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run_lo_q | run_hi_q),
    .tick_o (tick)
  );

  cyc_timer_src u_src (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_in_i  (cnt_in_i),
    .ext_sel_i (ext_q),
    .tick_i    (tick),
    .step_o    (step_main)
  );

  assign split     = mode_q == MODE_SPLIT;
  // outside split mode both bytes form one counter, so either write stalls it
  assign cancel_lo = split ? wr_lo : (wr_lo | wr_hi);
  assign inc_lo    = run_lo_q && step_main && !cancel_lo;
  assign inc_hi    = split && run_hi_q && tick && !wr_hi;

  cyc_timer_core u_core (
    .mode_i    (mode_q),
    .lo_i      (cnt_lo_q),
    .hi_i      (cnt_hi_q),
    .step_lo_i (inc_lo),
    .step_hi_i (inc_hi),
    .lo_o      (lo_nxt),
    .hi_o      (hi_nxt),
    .ovf_lo_o  (evt_lo),
    .ovf_hi_o  (evt_hi)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_lo_q <= '0;
      cnt_hi_q <= '0;
    end else begin
      cnt_lo_q <= wr_lo ? reg_wdata_i : lo_nxt;
      cnt_hi_q <= wr_hi ? reg_wdata_i : hi_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_13B;
      run_lo_q <= 1'b0;
      run_hi_q <= 1'b0;
      ext_q    <= 1'b0;
      ie_q     <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= tmr_mode_e'(reg_wdata_i[1:0]);
      if (wr_ctrl) begin
        run_lo_q <= reg_wdata_i[CTL_RUN];
        run_hi_q <= reg_wdata_i[CTL_RUN_HI];
        ext_q    <= reg_wdata_i[CTL_EXT];
        ie_q     <= reg_wdata_i[CTL_IE];
      end
    end
  end

  // a wrap beats both a control write and an acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q    <= 1'b0;
      ovf_hi_q <= 1'b0;
    end else begin
      if (evt_lo)         ovf_q <= 1'b1;
      else if (wr_ctrl)   ovf_q <= reg_wdata_i[CTL_OVF];
      else if (irq_ack_i) ovf_q <= 1'b0;
      if (evt_hi)         ovf_hi_q <= 1'b1;
      else if (wr_ctrl)   ovf_hi_q <= reg_wdata_i[CTL_OVF_HI];
      else if (irq_ack_i) ovf_hi_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr_i)
      ADDR_LO:   reg_rdata_o = cnt_lo_q;
      ADDR_HI:   reg_rdata_o = cnt_hi_q;
      ADDR_MODE: reg_rdata_o = {6'd0, mode_q};
      default:   reg_rdata_o = {2'd0, ie_q, ovf_hi_q, ovf_q, ext_q, run_hi_q, run_lo_q};
    endcase
  end

  assign ovf_o    = ovf_q;
  assign ovf_hi_o = ovf_hi_q;
  assign irq_o    = ie_q & (ovf_q | ovf_hi_q);
endmodule

// File: rtl/cyc_timer_chk.sv
module cyc_timer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic [1:0] reg_addr_i,
  input logic [7:0] reg_wdata_i,
  input logic       irq_ack_i,
  input logic [1:0] mode_q,
  input logic [7:0] cnt_lo_q,
  input logic [7:0] cnt_hi_q,
  input logic       run_lo_q,
  input logic       run_hi_q,
  input logic       tick,
  input logic       ovf_o,
  input logic       ovf_hi_o,
  input logic       irq_o
);
  a_r11_irq_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ovf_o || ovf_hi_o));

  a_r4_wrap_13b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'd0 && $rose(ovf_o) && !$past(reg_we_i))
      |-> (cnt_lo_q[4:0] == 5'd0 && cnt_hi_q == 8'd0));

  a_r5_wrap_16b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'd1 && $rose(ovf_o) && !$past(reg_we_i))
      |-> (cnt_lo_q == 8'd0 && cnt_hi_q == 8'd0));

  a_r6_reload_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'd2 && $rose(ovf_o) && !$past(reg_we_i))
      |-> (cnt_lo_q == cnt_hi_q));

  a_r9_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 2'd0) |=> (cnt_lo_q == $past(reg_wdata_i)));

  a_r10_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !reg_we_i && mode_q == 2'd1)
      |=> (!ovf_o || (cnt_lo_q == 8'd0 && cnt_hi_q == 8'd0)));

  a_r3_tick_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> !tick);

  a_r2_halt_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_lo_q && !run_hi_q && !reg_we_i) |=> ($stable(cnt_lo_q) && $stable(cnt_hi_q)));
endmodule

bind cyc_timer cyc_timer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .irq_ack_i  (irq_ack_i),
  .mode_q     (mode_q),
  .cnt_lo_q   (cnt_lo_q),
  .cnt_hi_q   (cnt_hi_q),
  .run_lo_q   (run_lo_q),
  .run_hi_q   (run_hi_q),
  .tick       (tick),
  .ovf_o      (ovf_o),
  .ovf_hi_o   (ovf_hi_o),
  .irq_o      (irq_o)
);

// File: tb/cyc_timer_tb.sv
`timescale 1ns/1ps
module cyc_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       cnt_in = 1'b0;
  logic       ack = 1'b0;
  logic       ovf, ovf_hi, irq;
  int         n_tests = 0;
  int         n_fail = 0;
  logic [7:0] r, r2;

  always #2.5 clk = ~clk;

  cyc_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .cnt_in_i(cnt_in),
    .irq_ack_i(ack), .ovf_o(ovf), .ovf_hi_o(ovf_hi), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    cnt_in = 1'b1;
    @(negedge clk);
    cnt_in = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [8:0] reload_model(input logic [7:0] lo, input logic [7:0] hi, input int n);
    logic f = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (lo == 8'hFF) begin lo = hi; f = 1'b1; end
      else lo = lo + 8'd1;
    end
    return {f, lo};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), r);
      chk("R1 reg", {8'd0, r}, 16'h0000);
    end
    chk("R1 flags", {13'd0, ovf, ovf_hi, irq}, 16'h0000);

    // R2 readback, R10 flags by write, R11 irq mask
    wr(2'd2, 8'h02); rd(2'd2, r); chk("R2 mode", {8'd0, r}, 16'h0002);
    wr(2'd3, 8'h24); rd(2'd3, r); chk("R2 ctrl", {8'd0, r}, 16'h0024);
    wr(2'd3, 8'h38); chk("R11 irq on", {13'd0, ovf, ovf_hi, irq}, 16'h0007);
    wr(2'd3, 8'h18); chk("R11 irq masked", {13'd0, ovf, ovf_hi, irq}, 16'h0006);
    wr(2'd3, 8'h00); chk("R10 write clear", {13'd0, ovf, ovf_hi, irq}, 16'h0000);

    // R3 machine-cycle spacing
    wr(2'd2, 8'h01); wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd3, 8'h01);
    wait_n(11); rd(2'd0, r); chk("R3 before first", {8'd0, r}, 16'h0000);
    wait_n(1);  rd(2'd0, r); chk("R3 first step", {8'd0, r}, 16'h0001);
    wait_n(60); rd(2'd0, r); chk("R3 six steps", {8'd0, r}, 16'h0006);

    // R5 16-bit preset 0xFC18
    wr(2'd3, 8'h00); wr(2'd0, 8'h18); wr(2'd1, 8'hFC); wr(2'd3, 8'h01);
    wait_n(11999);
    rd(2'd0, r); rd(2'd1, r2);
    chk("R5 before wrap", {r2, r}, 16'hFFFF); chk("R5 no flag", {15'd0, ovf}, 16'd0);
    wait_n(1);
    rd(2'd0, r); rd(2'd1, r2);
    chk("R5 wrap", {r2, r}, 16'h0000); chk("R5 flag", {15'd0, ovf}, 16'd1);
    wr(2'd3, 8'h01); chk("R10 write clear run", {15'd0, ovf}, 16'd0);
    wr(2'd3, 8'h29); chk("R11 irq", {15'd0, irq}, 16'd1);
    @(negedge clk); ack = 1'b1; @(negedge clk); ack = 1'b0;
    chk("R10 ack clear", {14'd0, ovf, irq}, 16'd0);

    // R4 13-bit
    wr(2'd3, 8'h00); wr(2'd2, 8'h00); wr(2'd0, 8'hFE); wr(2'd1, 8'hFF); wr(2'd3, 8'h01);
    wait_n(12); rd(2'd0, r); rd(2'd1, r2);
    chk("R4 step", {r2, r}, 16'hFFFF); chk("R4 no flag", {15'd0, ovf}, 16'd0);
    wait_n(12); rd(2'd0, r); rd(2'd1, r2);
    chk("R4 wrap keeps 7:5", {r2, r}, 16'h00E0); chk("R4 flag", {15'd0, ovf}, 16'd1);

    // R6 auto-reload
    wr(2'd3, 8'h00); wr(2'd2, 8'h02); wr(2'd1, 8'h80); wr(2'd0, 8'hFE); wr(2'd3, 8'h01);
    wait_n(12); rd(2'd0, r); chk("R6 step", {8'd0, r}, 16'h00FF);
    wait_n(12); rd(2'd0, r); rd(2'd1, r2);
    chk("R6 reload", {r2, r}, 16'h8080); chk("R6 flag", {15'd0, ovf}, 16'd1);

    // R7 split mode
    wr(2'd3, 8'h00); wr(2'd2, 8'h03); wr(2'd0, 8'h00); wr(2'd1, 8'hFE); wr(2'd3, 8'h02);
    wait_n(24); rd(2'd0, r); rd(2'd1, r2);
    chk("R7 high wrap", {r2, r}, 16'h0000);
    chk("R7 flags", {14'd0, ovf, ovf_hi}, 16'h0001);
    wr(2'd3, 8'h00); wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd3, 8'h07);
    pulse(); pulse(); pulse();
    rd(2'd0, r); rd(2'd1, r2);
    chk("R7 independent low", {r2, r}, 16'h0003);

    // R8 external edges
    wr(2'd3, 8'h00); wr(2'd2, 8'h01); wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd3, 8'h05);
    cnt_in = 1'b1; wait_n(3); cnt_in = 1'b0; wait_n(1);
    rd(2'd0, r); chk("R8 level once", {8'd0, r}, 16'h0001);
    pulse(); pulse();
    rd(2'd0, r); chk("R8 two edges", {8'd0, r}, 16'h0003);
    wr(2'd3, 8'h04); pulse();
    rd(2'd0, r); chk("R8 stopped", {8'd0, r}, 16'h0003);

    // R9 write beats step
    wr(2'd3, 8'h05);
    @(negedge clk); cnt_in = 1'b1; we = 1'b1; addr = 2'd0; wdata = 8'h55;
    @(negedge clk); cnt_in = 1'b0; we = 1'b0;
    rd(2'd0, r); chk("R9 low write", {8'd0, r}, 16'h0055);
    @(negedge clk); cnt_in = 1'b1; we = 1'b1; addr = 2'd1; wdata = 8'h12;
    @(negedge clk); cnt_in = 1'b0; we = 1'b0;
    rd(2'd0, r); rd(2'd1, r2); chk("R9 high write stalls", {r2, r}, 16'h1255);

    // random: 16-bit external counting
    for (int it = 0; it < 8; it++) begin
      logic [15:0] pre;
      int n;
      logic [16:0] sum;
      pre = {8'hFF, 8'($urandom)};
      n = int'($urandom % 300);
      sum = {1'b0, pre} + 17'(n);
      wr(2'd3, 8'h00); wr(2'd2, 8'h01); wr(2'd0, pre[7:0]); wr(2'd1, pre[15:8]); wr(2'd3, 8'h05);
      for (int p = 0; p < n; p++) pulse();
      rd(2'd0, r); rd(2'd1, r2);
      chk("R5 R8 random count", {r2, r}, sum[15:0]);
      chk("R5 random flag", {15'd0, ovf}, {15'd0, sum[16]});
    end

    // random: reload mode external counting
    for (int it = 0; it < 8; it++) begin
      logic [7:0] lo0, hi0;
      int n;
      logic [8:0] m;
      lo0 = 8'($urandom); hi0 = 8'($urandom);
      n = int'($urandom % 400);
      m = reload_model(lo0, hi0, n);
      wr(2'd3, 8'h00); wr(2'd2, 8'h02); wr(2'd1, hi0); wr(2'd0, lo0); wr(2'd3, 8'h05);
      for (int p = 0; p < n; p++) pulse();
      rd(2'd0, r); rd(2'd1, r2);
      chk("R6 random low", {8'd0, r}, {8'd0, m[7:0]});
      chk("R6 random high", {8'd0, r2}, {8'd0, hi0});
      chk("R6 random flag", {15'd0, ovf}, {15'd0, m[8]});
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule